// File: doc/BRIEF.md
# Scope Trace Capture and Raster Renderer

This block takes the stream of source-node amplitudes produced by a line emulator and shows them as an oscilloscope trace on a VGA monitor. On the simulation clock, each sample that arrives with its valid strobe is stored at the next address of a sample buffer, so that each address is one time step. On the separate pixel clock, the block runs a raster of column and row counters and derives the sync pulses from them. For every visible column it fetches the stored sample with that index and lights the pixel whose row matches the sample's scaled amplitude. No framebuffer is kept.

Two buffers alternate. The capture side fills one while the display reads the other. When a buffer is full, its completion crosses into the pixel domain through a two-flop synchronizer. The display takes the new buffer only at the first line of vertical sync, and it returns an acknowledge toggle through a second synchronizer. Until that acknowledge arrives, the capture side drops incoming samples, so no displayed frame is ever rewritten. A re-arm input restarts the partially filled buffer from address 0.

Top module: `scope_trace_top`

## Requirements
- R1: The raster has H_VIS+H_FP+H_SW+H_BP pixels per line and V_VIS+V_FP+V_SW+V_BP lines per frame, with defaults of 640/16/96/48 and 480/10/2/33. hsync_n is low for columns H_VIS+H_FP to H_VIS+H_FP+H_SW-1, and vsync_n is low for rows V_VIS+V_FP to V_VIS+V_FP+V_SW-1.
- R2: Raster positions are counted row-major from column 0, row 0. On pixel clock edge k after reset release (k = 1, 2, ...), all outputs describe raster position k-1.
- R3: Outside the visible area (column >= H_VIS or row >= V_VIS), {red,green,blue} is 12'h000.
- R4: In a visible pixel whose row equals V_VIS/2 minus the signed sample shown for that column, the colour is 12'h0F0 (green only). A sample whose row falls outside 0..V_VIS-1 draws nothing.
- R5: Every other visible pixel on row V_VIS/2 is dim grey, 12'h444. The trace takes priority over this baseline. All remaining visible pixels are 12'h000.
- R6: Until the first completed buffer has been taken by the display, only the baseline is drawn, and a buffer completed during a frame does not appear in that frame.
- R7: Each sample accepted with smp_valid high is written to the next address, starting at 0. Column c shows the sample at address c. Cycles with smp_valid low write nothing.
- R8: Filling address H_VIS-1 completes a buffer. The display switches to it only at column 0 of the first vsync row, so the change takes effect from the next frame.
- R9: From the cycle after a buffer completes until the display has taken it, incoming samples are discarded. Writing then resumes at address 0 of the buffer that has been released.
- R10: A high rearm restarts writing at address 0 and discards the partial buffer. A sample presented with smp_valid in the same cycle as rearm is not stored.
- R11: While the pixel reset is low, hsync_n and vsync_n are high and {red,green,blue} is 12'h000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sim_clk | input | 1 | Simulation (capture) clock |
| sim_rst_n | input | 1 | Active-low reset, capture domain |
| smp_valid | input | 1 | Sample strobe |
| smp_data | input | SW | Signed source-node amplitude |
| rearm | input | 1 | Restart capture at address 0 |
| pix_clk | input | 1 | Pixel clock |
| pix_rst_n | input | 1 | Active-low reset, pixel domain |
| hsync_n | output | 1 | Horizontal sync, active low |
| vsync_n | output | 1 | Vertical sync, active low |
| red | output | 4 | Red channel |
| green | output | 4 | Green channel |
| blue | output | 4 | Blue channel |

## Verification
Two pairs of events can fall in the same cycle. A rearm can coincide with a valid sample, and a buffer can complete while the previous one is still waiting to be displayed. The bench pulses rearm together with a sample after a few junk writes. It judges the result by whether the next displayed frame matches the fresh buffer exactly with no shifted columns. It also writes a second full buffer right after the first, within one frame. The frame after the next vertical sync must show the first buffer, not the second.

// File: rtl/scope_pkg.sv
package scope_pkg;

  typedef struct packed {
    logic [3:0] r;
    logic [3:0] g;
    logic [3:0] b;
  } rgb_t;

  localparam rgb_t TRACE_RGB = '{r: 4'h0, g: 4'hF, b: 4'h0};
  localparam rgb_t AXIS_RGB  = '{r: 4'h4, g: 4'h4, b: 4'h4};
  localparam rgb_t DARK_RGB  = '{r: 4'h0, g: 4'h0, b: 4'h0};

  // Row on which a signed amplitude is plotted.
  function automatic int trace_row(input int center, input int amp);
    return center - amp;
  endfunction

  // True when pos lies in [start, start+len).
  function automatic logic in_window(input int pos, input int start, input int len);
    return (pos >= start) && (pos < start + len);
  endfunction

  function automatic rgb_t pixel_color(input logic active, input logic shown,
                                       input int row, input int center, input int amp);
    if (!active) return DARK_RGB;
    if (shown && row == trace_row(center, amp)) return TRACE_RGB;
    if (row == center) return AXIS_RGB;
    return DARK_RGB;
  endfunction

endpackage

// File: rtl/scope_capture.sv
module scope_capture #(
  parameter int DEPTH = 640,
  parameter int SW    = 8,
  parameter int AW    = 10
) (
  input  logic          sim_clk,
  input  logic          sim_rst_n,
  input  logic          smp_valid,
  input  logic [SW-1:0] smp_data,
  input  logic          rearm,
  input  logic          ack_tgl_pix,
  output logic          wr_en,
  output logic          wr_bank,
  output logic [AW-1:0] wr_addr,
  output logic [SW-1:0] wr_data,
  output logic          req_tgl
);

  localparam logic [AW-1:0] LAST_ADDR = AW'(DEPTH - 1);

  logic [1:0] ack_sync;
  logic       ack_seen;
  logic       pending;
  logic       at_last;

  assign ack_seen = ack_sync[1];
  assign pending  = (req_tgl != ack_seen);
  assign at_last  = (wr_addr == LAST_ADDR);
  assign wr_en    = smp_valid && !rearm && !pending;
  assign wr_data  = smp_data;

  always_ff @(posedge sim_clk or negedge sim_rst_n) begin
    if (!sim_rst_n) begin
      ack_sync <= '0;
      wr_addr  <= '0;
      wr_bank  <= 1'b1;
      req_tgl  <= 1'b0;
    end else begin
      ack_sync <= {ack_sync[0], ack_tgl_pix};
      if (rearm) begin
        wr_addr <= '0;
      end else if (wr_en) begin
        if (at_last) begin
          wr_addr <= '0;
          wr_bank <= ~wr_bank;
          req_tgl <= ~req_tgl;
        end else begin
          wr_addr <= wr_addr + 1'b1;
        end
      end
    end
  end

  p_addr_in_range_r7: assert property (@(posedge sim_clk) disable iff (!sim_rst_n)
    wr_addr <= LAST_ADDR);

  p_rearm_restart_r10: assert property (@(posedge sim_clk) disable iff (!sim_rst_n)
    rearm |=> wr_addr == '0);

  p_wait_at_zero_r9: assert property (@(posedge sim_clk) disable iff (!sim_rst_n)
    pending |-> wr_addr == '0);

  p_flip_after_last_r8: assert property (@(posedge sim_clk) disable iff (!sim_rst_n)
    !$stable(wr_bank) |-> ($past(wr_addr) == LAST_ADDR && !$stable(req_tgl)));

endmodule

// File: rtl/scope_sample_ram.sv
module scope_sample_ram #(
  parameter int DEPTH = 640,
  parameter int SW    = 8,
  parameter int AW    = 10
) (
  input  logic          wclk,
  input  logic          we,
  input  logic          wbank,
  input  logic [AW-1:0] waddr,
  input  logic [SW-1:0] wdata,
  input  logic          rclk,
  input  logic          rbank,
  input  logic [AW-1:0] raddr,
  output logic [SW-1:0] rdata
);

  logic [SW-1:0] bank0 [DEPTH];
  logic [SW-1:0] bank1 [DEPTH];

  always_ff @(posedge wclk) begin
    if (we && !wbank) bank0[waddr] <= wdata;
    if (we &&  wbank) bank1[waddr] <= wdata;
  end

  always_ff @(posedge rclk) begin
    rdata <= rbank ? bank1[raddr] : bank0[raddr];
  end

endmodule

// File: rtl/scope_raster.sv
module scope_raster #(
  parameter int H_TOT  = 800,
  parameter int V_TOT  = 525,
  parameter int VS_ROW = 490,
  parameter int HW     = 10,
  parameter int VW     = 10
) (
  input  logic          pix_clk,
  input  logic          pix_rst_n,
  output logic [HW-1:0] hcnt,
  output logic [VW-1:0] vcnt,
  output logic          vs_start
);

  localparam logic [HW-1:0] H_LAST = HW'(H_TOT - 1);
  localparam logic [VW-1:0] V_LAST = VW'(V_TOT - 1);
  localparam logic [VW-1:0] V_SYNC = VW'(VS_ROW);

  logic line_end;

  assign line_end = (hcnt == H_LAST);
  assign vs_start = (hcnt == '0) && (vcnt == V_SYNC);

  always_ff @(posedge pix_clk or negedge pix_rst_n) begin
    if (!pix_rst_n) begin
      hcnt <= '0;
      vcnt <= '0;
    end else if (line_end) begin
      hcnt <= '0;
      vcnt <= (vcnt == V_LAST) ? '0 : vcnt + 1'b1;
    end else begin
      hcnt <= hcnt + 1'b1;
    end
  end

  p_line_wrap_r1: assert property (@(posedge pix_clk) disable iff (!pix_rst_n)
    hcnt == H_LAST |=> (hcnt == '0 && vcnt != $past(vcnt)));

  p_row_bound_r1: assert property (@(posedge pix_clk) disable iff (!pix_rst_n)
    vcnt <= V_LAST);

endmodule

// File: rtl/scope_render.sv
module scope_render
  import scope_pkg::*;
#(
  parameter int H_VIS = 640,
  parameter int H_FP  = 16,
  parameter int H_SW  = 96,
  parameter int V_VIS = 480,
  parameter int V_FP  = 10,
  parameter int V_SW  = 2,
  parameter int SW    = 8,
  parameter int AW    = 10,
  parameter int HW    = 10,
  parameter int VW    = 10
) (
  input  logic          pix_clk,
  input  logic          pix_rst_n,
  input  logic [HW-1:0] hcnt,
  input  logic [VW-1:0] vcnt,
  input  logic          vs_start,
  input  logic [SW-1:0] rdata,
  input  logic          req_tgl_sim,
  output logic          rd_bank,
  output logic [AW-1:0] rd_addr,
  output logic          ack_tgl,
  output logic          hsync_n,
  output logic          vsync_n,
  output logic [3:0]    red,
  output logic [3:0]    green,
  output logic [3:0]    blue
);

  localparam int CENTER = V_VIS / 2;

  logic [1:0]    req_sync;
  logic          swap;
  logic          shown;
  logic          act_d;
  logic [VW-1:0] row_d;
  logic          col_vis;
  logic          row_vis;
  rgb_t          px;

  assign col_vis = int'(hcnt) < H_VIS;
  assign row_vis = int'(vcnt) < V_VIS;
  assign rd_addr = col_vis ? AW'(hcnt) : '0;
  assign swap    = vs_start && (req_sync[1] != ack_tgl);

  always_ff @(posedge pix_clk or negedge pix_rst_n) begin
    if (!pix_rst_n) begin
      req_sync <= '0;
      ack_tgl  <= 1'b0;
      rd_bank  <= 1'b0;
      shown    <= 1'b0;
      act_d    <= 1'b0;
      row_d    <= '0;
      hsync_n  <= 1'b1;
      vsync_n  <= 1'b1;
    end else begin
      req_sync <= {req_sync[0], req_tgl_sim};
      if (swap) begin
        rd_bank <= ~rd_bank;
        ack_tgl <= ~ack_tgl;
        shown   <= 1'b1;
      end
      act_d   <= col_vis && row_vis;
      row_d   <= vcnt;
      hsync_n <= !in_window(int'(hcnt), H_VIS + H_FP, H_SW);
      vsync_n <= !in_window(int'(vcnt), V_VIS + V_FP, V_SW);
    end
  end

  assign px = pixel_color(act_d, shown, int'(row_d), CENTER, int'($signed(rdata)));
  assign {red, green, blue} = px;

  p_sync_black_r3: assert property (@(posedge pix_clk) disable iff (!pix_rst_n)
    (!hsync_n || !vsync_n) |-> {red, green, blue} == 12'h000);

  p_swap_in_vsync_r8: assert property (@(posedge pix_clk) disable iff (!pix_rst_n)
    !$stable(rd_bank) |-> $past(vs_start));

  p_no_trace_before_swap_r6: assert property (@(posedge pix_clk) disable iff (!pix_rst_n)
    (!shown && act_d) |-> (green == 4'h0 || green == 4'h4));

endmodule

// File: rtl/scope_trace_top.sv
module scope_trace_top #(
  parameter int H_VIS = 640,
  parameter int H_FP  = 16,
  parameter int H_SW  = 96,
  parameter int H_BP  = 48,
  parameter int V_VIS = 480,
  parameter int V_FP  = 10,
  parameter int V_SW  = 2,
  parameter int V_BP  = 33,
  parameter int SW    = 8
) (
  input  logic          sim_clk,
  input  logic          sim_rst_n,
  input  logic          smp_valid,
  input  logic [SW-1:0] smp_data,
  input  logic          rearm,
  input  logic          pix_clk,
  input  logic          pix_rst_n,
  output logic          hsync_n,
  output logic          vsync_n,
  output logic [3:0]    red,
  output logic [3:0]    green,
  output logic [3:0]    blue
);

  localparam int H_TOT = H_VIS + H_FP + H_SW + H_BP;
  localparam int V_TOT = V_VIS + V_FP + V_SW + V_BP;
  localparam int HW    = $clog2(H_TOT);
  localparam int VW    = $clog2(V_TOT);
  localparam int AW    = $clog2(H_VIS);

  logic          wr_en;
  logic          wr_bank;
  logic [AW-1:0] wr_addr;
  logic [SW-1:0] wr_data;
  logic          req_tgl;
  logic          ack_tgl;
  logic          rd_bank;
  logic [AW-1:0] rd_addr;
  logic [SW-1:0] rdata;
  logic [HW-1:0] hcnt;
  logic [VW-1:0] vcnt;
  logic          vs_start;

  scope_capture #(.DEPTH(H_VIS), .SW(SW), .AW(AW)) u_capture (
    .sim_clk     (sim_clk),
    .sim_rst_n   (sim_rst_n),
    .smp_valid   (smp_valid),
    .smp_data    (smp_data),
    .rearm       (rearm),
    .ack_tgl_pix (ack_tgl),
    .wr_en       (wr_en),
    .wr_bank     (wr_bank),
    .wr_addr     (wr_addr),
    .wr_data     (wr_data),
    .req_tgl     (req_tgl)
  );

  scope_sample_ram #(.DEPTH(H_VIS), .SW(SW), .AW(AW)) u_ram (
    .wclk  (sim_clk),
    .we    (wr_en),
    .wbank (wr_bank),
    .waddr (wr_addr),
    .wdata (wr_data),
    .rclk  (pix_clk),
    .rbank (rd_bank),
    .raddr (rd_addr),
    .rdata (rdata)
  );

  scope_raster #(
    .H_TOT(H_TOT), .V_TOT(V_TOT), .VS_ROW(V_VIS + V_FP), .HW(HW), .VW(VW)
  ) u_raster (
    .pix_clk   (pix_clk),
    .pix_rst_n (pix_rst_n),
    .hcnt      (hcnt),
    .vcnt      (vcnt),
    .vs_start  (vs_start)
  );

  scope_render #(
    .H_VIS(H_VIS), .H_FP(H_FP), .H_SW(H_SW),
    .V_VIS(V_VIS), .V_FP(V_FP), .V_SW(V_SW),
    .SW(SW), .AW(AW), .HW(HW), .VW(VW)
  ) u_render (
    .pix_clk     (pix_clk),
    .pix_rst_n   (pix_rst_n),
    .hcnt        (hcnt),
    .vcnt        (vcnt),
    .vs_start    (vs_start),
    .rdata       (rdata),
    .req_tgl_sim (req_tgl),
    .rd_bank     (rd_bank),
    .rd_addr     (rd_addr),
    .ack_tgl     (ack_tgl),
    .hsync_n     (hsync_n),
    .vsync_n     (vsync_n),
    .red         (red),
    .green       (green),
    .blue        (blue)
  );

endmodule

// File: tb/tb_scope_trace_top.sv
module tb_scope_trace_top;

  localparam int HV = 16, HFP = 2, HS = 3, HBP = 3;
  localparam int VV = 12, VFP = 2, VS = 1, VBP = 2;
  localparam int HT = HV + HFP + HS + HBP;
  localparam int VT = VV + VFP + VS + VBP;
  localparam int FRAME = HT * VT;
  localparam int CENTER = VV / 2;

  logic sim_clk = 0, pix_clk = 0;
  logic sim_rst_n = 0, pix_rst_n = 0;
  logic smp_valid = 0, rearm = 0;
  logic [7:0] smp_data = '0;
  logic hsync_n, vsync_n;
  logic [3:0] red, green, blue;

  scope_trace_top #(
    .H_VIS(HV), .H_FP(HFP), .H_SW(HS), .H_BP(HBP),
    .V_VIS(VV), .V_FP(VFP), .V_SW(VS), .V_BP(VBP), .SW(8)
  ) dut (.*);

  always #2 pix_clk = ~pix_clk;
  always #5 sim_clk = ~sim_clk;

  int checks = 0, errors = 0, nedge = 0;
  bit done = 0;
  logic signed [7:0] cur_buf [HV];
  logic signed [7:0] pend_buf [HV];
  logic signed [7:0] nbuf [HV];
  bit cur_shown = 0;
  string vis_tag = "R6";

  int sync_bad = 0, blank_bad = 0, vis_bad = 0;
  int sync_act, sync_exp, blank_act, vis_act, vis_exp;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [11:0] exp_pixel(input int h, input int v);
    if (h >= HV || v >= VV) return 12'h000;
    if (cur_shown && (v + int'(cur_buf[h]) == CENTER)) return 12'h0F0;
    if (v == CENTER) return 12'h444;
    return 12'h000;
  endfunction

  function automatic logic [7:0] rnd_sample();
    return 8'(int'($urandom % 13) - 6);
  endfunction

  always @(posedge pix_clk) if (pix_rst_n) nedge <= nedge + 1;

  int p, h, v;
  logic [11:0] ea, aa;
  logic hs_e, vs_e;
  always @(negedge pix_clk) begin
    if (pix_rst_n && nedge >= 1 && !done) begin
      p = (nedge - 1) % FRAME; h = p % HT; v = p / HT;
      hs_e = !(h >= HV + HFP && h < HV + HFP + HS);
      vs_e = !(v >= VV + VFP && v < VV + VFP + VS);
      aa = {red, green, blue};
      ea = exp_pixel(h, v);
      if (hsync_n !== hs_e || vsync_n !== vs_e) begin
        if (sync_bad == 0) begin sync_act = {hsync_n, vsync_n}; sync_exp = {hs_e, vs_e}; end
        sync_bad++;
      end
      if (aa !== ea) begin
        if (h < HV && v < VV) begin
          if (vis_bad == 0) begin vis_act = aa; vis_exp = ea; end
          vis_bad++;
        end else begin
          if (blank_bad == 0) blank_act = aa;
          blank_bad++;
        end
      end
      if (p == FRAME - 1) begin
        check(sync_bad == 0, "R1 R2 sync timing", sync_act, sync_exp);
        check(blank_bad == 0, "R3 blanking", blank_act, 0);
        check(vis_bad == 0, {"R4 R5 visible ", vis_tag}, vis_act, vis_exp);
        sync_bad = 0; blank_bad = 0; vis_bad = 0;
      end
    end
  end

  task automatic drive(input bit vld, input logic [7:0] d, input bit ra);
    @(negedge sim_clk);
    smp_valid = vld; smp_data = d; rearm = ra;
  endtask

  task automatic fill(input bit gaps);
    for (int i = 0; i < HV; i++) begin
      if (gaps && ($urandom % 3 == 0)) drive(0, 8'h55, 0);
      drive(1, nbuf[i], 0);
    end
    drive(0, 8'h00, 0);
  endtask

  task automatic make_rand();
    for (int i = 0; i < HV; i++) nbuf[i] = rnd_sample();
  endtask

  initial begin
    int seed;
    seed = $urandom(32'd2024);
    for (int i = 0; i < HV; i++) cur_buf[i] = 0;
    repeat (4) @(negedge sim_clk);
    // R11: reset state
    @(negedge pix_clk);
    check(hsync_n === 1'b1 && vsync_n === 1'b1 && {red, green, blue} === 12'h000,
          "R11 reset outputs", {hsync_n, vsync_n, red, green, blue}, 14'h3000);
    @(negedge pix_clk) pix_rst_n = 1;
    @(negedge sim_clk) sim_rst_n = 1;

    // Buffer A with directed corners, then B immediately (must be dropped, R9)
    @(negedge vsync_n);
    make_rand();
    nbuf[0] = 8'sd6; nbuf[1] = -8'sd5; nbuf[2] = 8'sd0; nbuf[3] = -8'sd6; nbuf[15] = 8'sd7;
    fill(1);
    pend_buf = nbuf;
    for (int i = 0; i < HV; i++) nbuf[i] = 8'(i % 5 - 2);
    fill(0);
    // Frame in flight still baseline only (R6, R8)
    @(negedge vsync_n);
    cur_buf = pend_buf; cur_shown = 1; vis_tag = "R7 R8 R9";

    // Junk partial fill, rearm with coincident sample, then buffer C (R10)
    @(negedge vsync_n);
    for (int i = 0; i < 5; i++) drive(1, 8'sd3, 0);
    drive(1, 8'sd5, 1);
    make_rand();
    nbuf[0] = 8'sd0; nbuf[HV-1] = -8'sd1;
    fill(0);
    pend_buf = nbuf;
    @(negedge vsync_n);
    cur_buf = pend_buf; vis_tag = "R10";

    // Random rounds with gaps in the strobe (R7)
    for (int r = 0; r < 3; r++) begin
      @(negedge vsync_n);
      make_rand();
      fill(1);
      pend_buf = nbuf;
      @(negedge vsync_n);
      cur_buf = pend_buf; vis_tag = "R7 random";
    end
    @(negedge vsync_n);
    @(negedge vsync_n);
    @(negedge pix_clk);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", nedge, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule